// File: doc/BRIEF.md
# Two-Point Similarity Model Solver

This block fits a rotation, isotropic scale and translation model to a pair of point correspondences. Each correspondence links a point in the current frame to a point in the previous frame. Every coordinate is an unsigned 11-bit pixel position. The model maps a previous-frame point (u, v) to a current-frame point:

- x = (A·u − B·v + tx) / 256
- y = (B·u + A·v + ty) / 256

Here A stands for scale·cos(angle) and B for scale·sin(angle). All four parameters are integers carrying a fixed factor of 256.

The solver forms the coordinate differences inside each frame. It divides two pre-scaled products by the squared length of the previous-frame segment, and then derives the translation from the first correspondence. The block is fully pipelined, so a fresh pair can be presented on every clock. A result leaves the block a fixed three cycles after its pair was taken in. If both previous-frame points are identical, no model can be fitted; the block then raises a flag in place of a model. Drawing the sample pairs and scoring inliers against a model are handled elsewhere.

Top module: `simxf_solver`

## Requirements
- R1: With du = prv1_x − prv0_x, dv = prv1_y − prv0_y, dx = cur1_x − cur0_x, dy = cur1_y − cur0_y and D = du² + dv², mdl_a equals 256·(dy·dv + dx·du) / D.
- R2: mdl_b equals 256·(dy·du − dx·dv) / D.
- R3: mdl_tx equals 256·cur0_x − mdl_a·prv0_x + mdl_b·prv0_y, computed with the returned mdl_a and mdl_b.
- R4: mdl_ty equals 256·cur0_y − mdl_b·prv0_x − mdl_a·prv0_y, computed with the returned mdl_a and mdl_b.
- R5: Both divisions are signed and truncate toward zero. For example, −768 / 9 gives −85, not −86.
- R6: A pair with prv0 equal to prv1 is degenerate. Three cycles after it is taken in, mdl_degen is 1 and mdl_vld is 0. The two flags are never high together.
- R7: A non-degenerate pair taken in with pair_vld = 1 on one clock edge produces mdl_vld = 1 and mdl_degen = 0 after exactly three clock edges. The strobe lasts one cycle per pair.
- R8: Pairs on consecutive cycles are solved independently. Each result appears in its own cycle, in input order.
- R9: A cycle with pair_vld = 0 produces neither mdl_vld nor mdl_degen three cycles later, whatever values the coordinate inputs carry.
- R10: Reset is synchronous and active low. It clears mdl_vld and mdl_degen at the next edge. A pair taken in before a reset never produces a result.
- R11: Coordinates across the full 0..2047 range, including the smallest non-zero D (1) and the largest D (2·2047²), give exact results without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pair_vld | input | 1 | The coordinate inputs carry a pair this cycle |
| cur0_x | input | COORD_W | First current-frame point, X |
| cur0_y | input | COORD_W | First current-frame point, Y |
| cur1_x | input | COORD_W | Second current-frame point, X |
| cur1_y | input | COORD_W | Second current-frame point, Y |
| prv0_x | input | COORD_W | First previous-frame point, X |
| prv0_y | input | COORD_W | First previous-frame point, Y |
| prv1_x | input | COORD_W | Second previous-frame point, X |
| prv1_y | input | COORD_W | Second previous-frame point, Y |
| mdl_vld | output | 1 | A model is present on the outputs this cycle |
| mdl_degen | output | 1 | The pair from three cycles earlier was degenerate |
| mdl_a | output | 2·COORD_W+FRAC_BITS+3 | Signed scale·cos term, ×256 |
| mdl_b | output | 2·COORD_W+FRAC_BITS+3 | Signed scale·sin term, ×256 |
| mdl_tx | output | 3·COORD_W+FRAC_BITS+6 | Signed X translation, ×256 |
| mdl_ty | output | 3·COORD_W+FRAC_BITS+6 | Signed Y translation, ×256 |

## Verification
Every result is due on the third rising edge after the edge that took in its pair. The bench drives inputs on falling edges. When it drives table entry t, on that same falling edge it checks the result for entry t − 3, so each comparison lands in the middle of the cycle the result occupies.

The vector walk presents pairs back to back. Each output cycle therefore belongs to exactly one input, and a result that arrives one cycle early or late is read against the wrong expectation. Directed tests cover the other cases by counting the same three edges: a gap between pairs, idle cycles carrying random data, and a reset that arrives while a pair is in flight.

// File: rtl/simxf_pkg.sv
`timescale 1ns/1ps
// Shared width arithmetic for the similarity solver.
// Assumes unsigned coordinates of cw bits and fb fraction bits of scaling.
package simxf_pkg;
    localparam int PIPE_DEPTH = 3;

    // Signed width of a difference between two unsigned coordinates.
    function automatic int diff_width(input int cw);
        return cw + 1;
    endfunction

    // Signed width of a pre-scaled numerator, the divisor and a quotient.
    function automatic int ratio_width(input int cw, input int fb);
        return 2 * (cw + 1) + 1 + fb;
    endfunction

    // Signed width of a translation term.
    function automatic int shift_width(input int cw, input int fb);
        return ratio_width(cw, fb) + cw + 3;
    endfunction
endpackage

// File: rtl/simxf_diff.sv
`timescale 1ns/1ps
// Stage 1: forms the in-frame differences, the two pre-scaled numerators and the
// squared-length divisor, and registers them with the first sample of the pair.
// Assumes unsigned coordinates. The degenerate test looks only at previous-frame points.
module simxf_diff
    import simxf_pkg::*;
#(
    parameter int COORD_W   = 11,
    parameter int FRAC_BITS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_vld,
    input  logic [COORD_W-1:0]            c0x,
    input  logic [COORD_W-1:0]            c0y,
    input  logic [COORD_W-1:0]            c1x,
    input  logic [COORD_W-1:0]            c1y,
    input  logic [COORD_W-1:0]            p0x,
    input  logic [COORD_W-1:0]            p0y,
    input  logic [COORD_W-1:0]            p1x,
    input  logic [COORD_W-1:0]            p1y,
    output logic                          s1_vld,
    output logic                          s1_degen,
    output logic signed [ratio_width(COORD_W, FRAC_BITS)-1:0] s1_num_a,
    output logic signed [ratio_width(COORD_W, FRAC_BITS)-1:0] s1_num_b,
    output logic signed [ratio_width(COORD_W, FRAC_BITS)-1:0] s1_den,
    output logic [COORD_W-1:0]            s1_c0x,
    output logic [COORD_W-1:0]            s1_c0y,
    output logic [COORD_W-1:0]            s1_p0x,
    output logic [COORD_W-1:0]            s1_p0y
);
    localparam int DW = diff_width(COORD_W);
    localparam int NW = ratio_width(COORD_W, FRAC_BITS);

    logic signed [DW-1:0] dxa, dya, dxb, dyb;
    logic signed [NW-1:0] pxx, pyy, pyx, pxy, sqx, sqy;
    logic signed [NW-1:0] dot, crs;

    // Signed differences inside each frame and the products built from them.
    always_comb begin
        dxa = signed'({1'b0, c1x}) - signed'({1'b0, c0x});
        dya = signed'({1'b0, c1y}) - signed'({1'b0, c0y});
        dxb = signed'({1'b0, p1x}) - signed'({1'b0, p0x});
        dyb = signed'({1'b0, p1y}) - signed'({1'b0, p0y});
        pxx = NW'(dxa) * NW'(dxb);
        pyy = NW'(dya) * NW'(dyb);
        pyx = NW'(dya) * NW'(dxb);
        pxy = NW'(dxa) * NW'(dyb);
        sqx = NW'(dxb) * NW'(dxb);
        sqy = NW'(dyb) * NW'(dyb);
        dot = pyy + pxx;
        crs = pyx - pxy;
    end

    // Register the stage-1 results together with the anchor sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_degen <= 1'b0;
            s1_num_a <= '0;
            s1_num_b <= '0;
            s1_den   <= '0;
            s1_c0x   <= '0;
            s1_c0y   <= '0;
            s1_p0x   <= '0;
            s1_p0y   <= '0;
        end else begin
            s1_vld   <= in_vld;
            s1_degen <= (dxb == '0) && (dyb == '0);
            s1_num_a <= dot <<< FRAC_BITS;
            s1_num_b <= crs <<< FRAC_BITS;
            s1_den   <= sqx + sqy;
            s1_c0x   <= c0x;
            s1_c0y   <= c0y;
            s1_p0x   <= p0x;
            s1_p0y   <= p0y;
        end
    end
endmodule

// File: rtl/simxf_sdiv.sv
`timescale 1ns/1ps
// Registered signed divider. The quotient truncates toward zero.
// Assumes the caller flags a zero divisor; the quotient is then forced to zero.
module simxf_sdiv #(
    parameter int W = 33
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] num,
    input  logic signed [W-1:0] den,
    input  logic                zero_den,
    output logic signed [W-1:0] quo_q
);
    // One division per cycle, result held in a register.
    always_ff @(posedge clk) begin
        if (!rst_n)        quo_q <= '0;
        else if (zero_den) quo_q <= '0;
        else               quo_q <= num / den;
    end
endmodule

// File: rtl/simxf_xlate.sv
`timescale 1ns/1ps
// Stage 3: derives the translation from the delayed first sample and the
// registered ratio terms, and issues the output strobe or degenerate flag.
// Assumes a and b are aligned with the anchor coordinates on its inputs.
module simxf_xlate
    import simxf_pkg::*;
#(
    parameter int COORD_W   = 11,
    parameter int FRAC_BITS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          s2_vld,
    input  logic                          s2_degen,
    input  logic [COORD_W-1:0]            c0x,
    input  logic [COORD_W-1:0]            c0y,
    input  logic [COORD_W-1:0]            p0x,
    input  logic [COORD_W-1:0]            p0y,
    input  logic signed [ratio_width(COORD_W, FRAC_BITS)-1:0] a,
    input  logic signed [ratio_width(COORD_W, FRAC_BITS)-1:0] b,
    output logic                          o_vld,
    output logic                          o_degen,
    output logic signed [ratio_width(COORD_W, FRAC_BITS)-1:0] o_a,
    output logic signed [ratio_width(COORD_W, FRAC_BITS)-1:0] o_b,
    output logic signed [shift_width(COORD_W, FRAC_BITS)-1:0] o_tx,
    output logic signed [shift_width(COORD_W, FRAC_BITS)-1:0] o_ty
);
    localparam int SW = shift_width(COORD_W, FRAC_BITS);

    logic signed [SW-1:0] xa, ya, xb, yb, ax, ay, bx, by;

    // Products of the ratio terms with the previous-frame anchor.
    always_comb begin
        xa = SW'(signed'({1'b0, c0x})) <<< FRAC_BITS;
        ya = SW'(signed'({1'b0, c0y})) <<< FRAC_BITS;
        xb = SW'(signed'({1'b0, p0x}));
        yb = SW'(signed'({1'b0, p0y}));
        ax = SW'(a) * xb;
        ay = SW'(a) * yb;
        bx = SW'(b) * xb;
        by = SW'(b) * yb;
    end

    // Register the model and split the strobe on degeneracy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_vld   <= 1'b0;
            o_degen <= 1'b0;
            o_a     <= '0;
            o_b     <= '0;
            o_tx    <= '0;
            o_ty    <= '0;
        end else begin
            o_vld   <= s2_vld && !s2_degen;
            o_degen <= s2_vld && s2_degen;
            o_a     <= a;
            o_b     <= b;
            o_tx    <= xa - ax + by;
            o_ty    <= ya - bx - ay;
        end
    end
endmodule

// File: rtl/simxf_solver.sv
`timescale 1ns/1ps
// Top: three-stage pipelined solver for the two-point rotation-scale-translation model.
// Stage 1 forms differences, stage 2 divides, stage 3 forms the translation.
// Assumes unsigned COORD_W-bit coordinates and accepts one pair per cycle.
module simxf_solver
    import simxf_pkg::*;
#(
    parameter int COORD_W   = 11,
    parameter int FRAC_BITS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pair_vld,
    input  logic [COORD_W-1:0]            cur0_x,
    input  logic [COORD_W-1:0]            cur0_y,
    input  logic [COORD_W-1:0]            cur1_x,
    input  logic [COORD_W-1:0]            cur1_y,
    input  logic [COORD_W-1:0]            prv0_x,
    input  logic [COORD_W-1:0]            prv0_y,
    input  logic [COORD_W-1:0]            prv1_x,
    input  logic [COORD_W-1:0]            prv1_y,
    output logic                          mdl_vld,
    output logic                          mdl_degen,
    output logic signed [ratio_width(COORD_W, FRAC_BITS)-1:0] mdl_a,
    output logic signed [ratio_width(COORD_W, FRAC_BITS)-1:0] mdl_b,
    output logic signed [shift_width(COORD_W, FRAC_BITS)-1:0] mdl_tx,
    output logic signed [shift_width(COORD_W, FRAC_BITS)-1:0] mdl_ty
);
    localparam int RW = ratio_width(COORD_W, FRAC_BITS);

    logic                 s1_vld, s1_degen;
    logic signed [RW-1:0] s1_den;
    logic signed [RW-1:0] s1_num [2];
    logic signed [RW-1:0] s2_quo [2];
    logic [COORD_W-1:0]   s1_c0x, s1_c0y, s1_p0x, s1_p0y;
    logic                 s2_vld, s2_degen;
    logic [COORD_W-1:0]   s2_c0x, s2_c0y, s2_p0x, s2_p0y;

    simxf_diff #(.COORD_W(COORD_W), .FRAC_BITS(FRAC_BITS)) i_diff (
        .clk(clk), .rst_n(rst_n), .in_vld(pair_vld),
        .c0x(cur0_x), .c0y(cur0_y), .c1x(cur1_x), .c1y(cur1_y),
        .p0x(prv0_x), .p0y(prv0_y), .p1x(prv1_x), .p1y(prv1_y),
        .s1_vld(s1_vld), .s1_degen(s1_degen),
        .s1_num_a(s1_num[0]), .s1_num_b(s1_num[1]), .s1_den(s1_den),
        .s1_c0x(s1_c0x), .s1_c0y(s1_c0y), .s1_p0x(s1_p0x), .s1_p0y(s1_p0y)
    );

    // Two identical dividers, one for each ratio term.
    for (genvar k = 0; k < 2; k++) begin : g_div
        simxf_sdiv #(.W(RW)) i_sdiv (
            .clk(clk), .rst_n(rst_n),
            .num(s1_num[k]), .den(s1_den), .zero_den(s1_degen),
            .quo_q(s2_quo[k])
        );
    end

    // Delay the control bits and the anchor sample to meet the quotients.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld   <= 1'b0;
            s2_degen <= 1'b0;
            s2_c0x   <= '0;
            s2_c0y   <= '0;
            s2_p0x   <= '0;
            s2_p0y   <= '0;
        end else begin
            s2_vld   <= s1_vld;
            s2_degen <= s1_degen;
            s2_c0x   <= s1_c0x;
            s2_c0y   <= s1_c0y;
            s2_p0x   <= s1_p0x;
            s2_p0y   <= s1_p0y;
        end
    end

    simxf_xlate #(.COORD_W(COORD_W), .FRAC_BITS(FRAC_BITS)) i_xlate (
        .clk(clk), .rst_n(rst_n), .s2_vld(s2_vld), .s2_degen(s2_degen),
        .c0x(s2_c0x), .c0y(s2_c0y), .p0x(s2_p0x), .p0y(s2_p0y),
        .a(s2_quo[0]), .b(s2_quo[1]),
        .o_vld(mdl_vld), .o_degen(mdl_degen), .o_a(mdl_a), .o_b(mdl_b),
        .o_tx(mdl_tx), .o_ty(mdl_ty)
    );
endmodule

// File: rtl/simxf_solver_chk.sv
`timescale 1ns/1ps
// Checker for the solver's strobe timing and flag behaviour, bound to the top.
module simxf_solver_chk #(
    parameter int COORD_W = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pair_vld,
    input logic [COORD_W-1:0] prv0_x,
    input logic [COORD_W-1:0] prv0_y,
    input logic [COORD_W-1:0] prv1_x,
    input logic [COORD_W-1:0] prv1_y,
    input logic               mdl_vld,
    input logic               mdl_degen
);
    logic same_prv;
    assign same_prv = ({prv0_x, prv0_y} == {prv1_x, prv1_y});

    AST_FIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld && !same_prv |-> ##3 (mdl_vld && !mdl_degen)); // R7
    AST_DEGEN_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld && same_prv |-> ##3 (mdl_degen && !mdl_vld)); // R6
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mdl_vld && mdl_degen)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_vld |-> ##3 (!mdl_vld && !mdl_degen)); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!mdl_vld && !mdl_degen)); // R10
endmodule

bind simxf_solver simxf_solver_chk #(.COORD_W(COORD_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .pair_vld(pair_vld),
    .prv0_x(prv0_x), .prv0_y(prv0_y), .prv1_x(prv1_x), .prv1_y(prv1_y),
    .mdl_vld(mdl_vld), .mdl_degen(mdl_degen)
);

// File: tb/test_simxf_solver.sv
`timescale 1ns/1ps
// Bench: a vector table walked back to back, then directed gap, idle and reset tests.
module test_simxf_solver;
    import simxf_pkg::*;
    localparam int CW = 11;
    localparam int FB = 8;
    localparam int RW = ratio_width(CW, FB);
    localparam int SW = shift_width(CW, FB);

    typedef struct packed {
        logic [CW-1:0] c0x, c0y, c1x, c1y, p0x, p0y, p1x, p1y;
        logic          degen;
        logic [1:0]    kind;   // 0 plain, 1 truncation, 2 extreme range
        longint        a, b, tx, ty;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{100, 200, 300, 250, 100, 200, 300, 250, 0, 0, 256, 0, 0, 0},
        '{55, 57, 155, 57, 50, 60, 150, 60, 0, 0, 256, 0, 1280, -768},
        '{500, 300, 500, 400, 100, 100, 200, 100, 0, 0, 0, 256, 153600, 51200},
        '{30, 40, 50, 40, 10, 20, 20, 20, 0, 0, 512, 0, 2560, 0},
        '{10, 10, 9, 10, 0, 0, 3, 0, 0, 1, -85, 0, 2560, 2560},
        '{100, 100, 101, 100, 4, 0, 4, 3, 0, 1, 0, -85, 25600, 25940},
        '{7, 9, 40, 41, 7, 9, 7, 9, 1, 0, 0, 0, 0, 0},
        '{0, 0, 2047, 2047, 0, 0, 2047, 2047, 0, 2, 256, 0, 0, 0},
        '{0, 0, 2047, 2047, 5, 5, 6, 5, 0, 2, 524032, 524032, 0, -5240320}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pair_vld = 1'b0;
    logic [CW-1:0] cur0_x = '0, cur0_y = '0, cur1_x = '0, cur1_y = '0;
    logic [CW-1:0] prv0_x = '0, prv0_y = '0, prv1_x = '0, prv1_y = '0;
    logic mdl_vld, mdl_degen;
    logic signed [RW-1:0] mdl_a, mdl_b;
    logic signed [SW-1:0] mdl_tx, mdl_ty;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    simxf_solver #(.COORD_W(CW), .FRAC_BITS(FB)) i_simxf_solver (
        .clk(clk), .rst_n(rst_n), .pair_vld(pair_vld),
        .cur0_x(cur0_x), .cur0_y(cur0_y), .cur1_x(cur1_x), .cur1_y(cur1_y),
        .prv0_x(prv0_x), .prv0_y(prv0_y), .prv1_x(prv1_x), .prv1_y(prv1_y),
        .mdl_vld(mdl_vld), .mdl_degen(mdl_degen), .mdl_a(mdl_a), .mdl_b(mdl_b),
        .mdl_tx(mdl_tx), .mdl_ty(mdl_ty)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        pair_vld = vld;
        cur0_x = v.c0x; cur0_y = v.c0y; cur1_x = v.c1x; cur1_y = v.c1y;
        prv0_x = v.p0x; prv0_y = v.p0y; prv1_x = v.p1x; prv1_y = v.p1y;
    endtask

    task automatic quiet(input string req);
        chk(mdl_vld == 1'b0, req, longint'(mdl_vld), 0);
        chk(mdl_degen == 1'b0, req, longint'(mdl_degen), 0);
    endtask

    task automatic check_vec(input int k);
        string tag;
        vec_t v;
        v = VECS[k];
        tag = (v.kind == 2'd1) ? "R5 trunc" : (v.kind == 2'd2) ? "R11 range" : "R8 stream";
        if (v.degen) begin
            chk(mdl_degen == 1'b1, $sformatf("R6 degen v%0d", k), longint'(mdl_degen), 1);
            chk(mdl_vld == 1'b0, $sformatf("R6 vld v%0d", k), longint'(mdl_vld), 0);
        end else begin
            chk(mdl_vld == 1'b1 && mdl_degen == 1'b0, $sformatf("R7 strobe v%0d", k),
                longint'({mdl_vld, mdl_degen}), 2);
            chk(longint'(mdl_a) == v.a, $sformatf("R1 a v%0d %s", k, tag), longint'(mdl_a), v.a);
            chk(longint'(mdl_b) == v.b, $sformatf("R2 b v%0d %s", k, tag), longint'(mdl_b), v.b);
            chk(longint'(mdl_tx) == v.tx, $sformatf("R3 tx v%0d %s", k, tag), longint'(mdl_tx), v.tx);
            chk(longint'(mdl_ty) == v.ty, $sformatf("R4 ty v%0d %s", k, tag), longint'(mdl_ty), v.ty);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        quiet("R10 reset state");
        rst_n = 1'b1;

        // Table walk: entry t driven while entry t-3 is checked on the same falling edge.
        for (int t = 0; t < NV + 3; t++) begin
            @(negedge clk);
            if (t >= 3) check_vec(t - 3);
            if (t < NV) drive(VECS[t], 1'b1);
            else        drive(VECS[0], 1'b0);
        end

        // R7 gap: one pair, one empty cycle, one pair; strobes only at +3.
        @(negedge clk); drive(VECS[1], 1'b1);
        @(negedge clk); drive(VECS[0], 1'b0);
        @(negedge clk); drive(VECS[3], 1'b1);
        @(negedge clk); drive(VECS[0], 1'b0);
        chk(mdl_vld == 1'b1 && longint'(mdl_tx) == 1280, "R7 gap first", longint'(mdl_tx), 1280);
        @(negedge clk);
        quiet("R7 gap hole");
        @(negedge clk);
        chk(mdl_vld == 1'b1 && longint'(mdl_a) == 512, "R7 gap second", longint'(mdl_a), 512);

        // R9 idle: data moves but no strobe is given.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 1) quiet("R9 idle");
            drive(VECS[(i * 4) % NV], 1'b0);
            cur1_x = CW'($urandom);
            prv1_y = CW'($urandom);
        end

        // R10 reset with a pair in flight: it must never come out.
        @(negedge clk); drive(VECS[2], 1'b1);
        @(negedge clk); drive(VECS[0], 1'b0); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        quiet("R10 after reset");
        @(negedge clk); quiet("R10 flush 1");
        @(negedge clk); quiet("R10 flush 2");
        @(negedge clk); quiet("R10 flush 3");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule